// File: doc/BRIEF.md
# Spawn-Join Virtual Thread Dispatcher

This block sits between one serial master core and a pool of parallel thread-control units. The master opens a parallel section by presenting an inclusive range of virtual thread identifiers. While the section is open, any unit that is free pulses a request. It then receives the next unused identifier from a shared counter, or a "no more work" answer once the range is used up. Units are not given fixed shares of the range, so a unit with short threads simply comes back more often. The units do not synchronise with each other, and nothing waits except at the end of the section.

Each unit runs the thread it was given and pulses its done strobe when that thread reaches the join. The unit then asks again. The section closes when the range is used up and no unit still holds a thread. A one-cycle join pulse then hands control back to the master. A second spawn while a section is open is refused and flagged. An empty range (upper bound below lower bound) closes at once.

Top module: `spawn_join_dispatcher`

## Requirements
- R1: With no section open, a spawn request is accepted. `spawn_accept` pulses and `section_busy` rises in the cycle after the request, and the first identifier handed out is the lower bound.
- R2: A spawn request while `section_busy` is high pulses `spawn_reject` one cycle later. The open section's range and counter are left unchanged.
- R3: A unit that pulses `unit_req` while identifiers remain sees `unit_gnt` one cycle later, with the current counter value on its `unit_id` field (bits `i*ID_W` upward). The counter advances by one for each grant.
- R4: Units that request in the same cycle receive distinct, consecutive identifiers. Lower unit indices receive lower identifiers.
- R5: A request made after the counter has passed the upper bound gets a `unit_none` pulse one cycle later and uses up no identifier.
- R6: In one section, every identifier in the range is granted exactly once and no identifier outside it is granted.
- R7: `join_done` is high for exactly one cycle, in the cycle after the range is used up and the last outstanding done strobe is seen. `section_busy` falls in that same cycle.
- R8: `join_done` never rises while a unit that holds a granted identifier has not yet pulsed done.
- R9: An empty range gives `join_done` one cycle after `spawn_accept`, and no unit is granted anything.
- R10: Requests and done strobes made while no section is open produce neither `unit_gnt` nor `unit_none`.
- R11: During and right after reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spawn_valid | input | 1 | Master asks to open a section |
| spawn_lo | input | ID_W | Lowest identifier of the range |
| spawn_hi | input | ID_W | Highest identifier of the range (inclusive) |
| spawn_accept | output | 1 | Spawn taken, one-cycle pulse |
| spawn_reject | output | 1 | Spawn refused because a section is open, one-cycle pulse |
| section_busy | output | 1 | A parallel section is open |
| unit_req | input | NUM_UNITS | Per-unit request strobe for the next identifier |
| unit_done | input | NUM_UNITS | Per-unit strobe: the current thread has reached the join |
| unit_gnt | output | NUM_UNITS | Per-unit grant pulse, valid identifier on unit_id |
| unit_none | output | NUM_UNITS | Per-unit pulse: the range is used up |
| unit_id | output | NUM_UNITS*ID_W | Packed granted identifiers, unit i in bits i*ID_W upward |
| join_done | output | 1 | Section closed, one-cycle pulse |

## Verification
The bench builds the block with four units and 8-bit identifiers. With these values a range such as 250..255 reaches the very top of the identifier space, where the counter must step past the largest code without wrapping. Sections longer than the unit count make units come back many times, and ranges of one or two identifiers leave most units with a "no more work" answer. A random per-unit model with thread durations of 0 to 6 cycles makes done strobes from different units land in the same cycle as requests, and in any order.

// File: rtl/sjd_pkg.sv
package sjd_pkg;

   // Section phase as seen by the master
   typedef enum logic {
      SEC_IDLE   = 1'b0,
      SEC_ACTIVE = 1'b1
   } sec_state_e;

   // Bits needed to count 0..n inclusive
   function automatic int count_bits(input int n);
      int b;
      b = 1;
      while ((1 << b) <= n) b++;
      return b;
   endfunction

endpackage

// File: rtl/sjd_section_ctrl.sv
module sjd_section_ctrl
   import sjd_pkg::*;
#(
   parameter int ID_W  = 8,
   parameter int CNT_W = 3,
   parameter int CW    = ID_W + CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             spawn_valid,
   input  logic [ID_W-1:0]  spawn_lo,
   input  logic [ID_W-1:0]  spawn_hi,
   input  logic [CNT_W-1:0] take_cnt,
   input  logic             units_clear,
   output logic             busy,
   output logic [CW-1:0]    next_id,
   output logic [CW-1:0]    hi_bound,
   output logic             exhausted,
   output logic             spawn_accept,
   output logic             spawn_reject,
   output logic             join_done
);

   sec_state_e state_q;
   logic       join_cond;

   assign busy      = (state_q == SEC_ACTIVE);
   assign exhausted = busy && (next_id > hi_bound);
   assign join_cond = exhausted && units_clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= SEC_IDLE;
         next_id      <= '0;
         hi_bound     <= '0;
         spawn_accept <= 1'b0;
         spawn_reject <= 1'b0;
         join_done    <= 1'b0;
      end else begin
         spawn_accept <= spawn_valid && !busy;
         spawn_reject <= spawn_valid && busy;
         join_done    <= join_cond;
         if (!busy) begin
            if (spawn_valid) begin
               state_q  <= SEC_ACTIVE;
               next_id  <= CW'(spawn_lo);
               hi_bound <= CW'(spawn_hi);
            end
         end else begin
            next_id <= next_id + CW'(take_cnt);
            if (join_cond) state_q <= SEC_IDLE;
         end
      end
   end

   // R1: an accepted spawn was made with no section open
   assert_accept_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      spawn_accept |-> (busy && !$past(busy)));

   // R2: reject and accept never together
   assert_reject_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      spawn_reject |-> !spawn_accept);

   // R5: once the range is used up the counter does not move
   assert_exhausted_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      exhausted |=> (next_id == $past(next_id)));

   // R7: the join pulse coincides with the section closing
   assert_join_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      join_done |-> (!busy && !$past(join_done)));

endmodule

// File: rtl/sjd_id_allocator.sv
module sjd_id_allocator #(
   parameter int NUM_UNITS = 4,
   parameter int ID_W      = 8,
   parameter int CNT_W     = 3,
   parameter int CW        = ID_W + CNT_W + 1
) (
   input  logic [NUM_UNITS-1:0]       req,
   input  logic                       busy,
   input  logic [CW-1:0]              next_id,
   input  logic [CW-1:0]              hi_bound,
   output logic [NUM_UNITS-1:0]       grant_now,
   output logic [NUM_UNITS-1:0]       deny_now,
   output logic [NUM_UNITS*ID_W-1:0]  id_now,
   output logic [CNT_W-1:0]           take_cnt
);

   // Each requester is ranked by the number of requesters below it; the
   // rank is its offset from the shared counter.
   for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
      logic [CNT_W-1:0] rank;
      logic [CW-1:0]    cand;
      logic             fits;

      always_comb begin
         rank = '0;
         for (int j = 0; j < i; j++) rank = rank + CNT_W'(req[j]);
      end

      assign cand               = next_id + CW'(rank);
      assign fits               = (cand <= hi_bound);
      assign grant_now[i]       = busy && req[i] && fits;
      assign deny_now[i]        = busy && req[i] && !fits;
      assign id_now[i*ID_W +: ID_W] = cand[ID_W-1:0];
   end

   always_comb begin
      take_cnt = '0;
      for (int k = 0; k < NUM_UNITS; k++) take_cnt = take_cnt + CNT_W'(grant_now[k]);
   end

endmodule

// File: rtl/sjd_unit_tracker.sv
module sjd_unit_tracker #(
   parameter int NUM_UNITS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_UNITS-1:0] grant_now,
   input  logic [NUM_UNITS-1:0] done,
   output logic [NUM_UNITS-1:0] active,
   output logic                 units_clear
);

   // A unit holds a thread from its grant until its done strobe
   for (genvar i = 0; i < NUM_UNITS; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) active[i] <= 1'b0;
         else        active[i] <= (active[i] && !done[i]) || grant_now[i];
      end

      // R6: a unit still holding a thread is never handed another one
      assert_no_double_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         grant_now[i] |-> !(active[i] && !done[i]));
   end

   assign units_clear = ((active & ~done) == '0);

endmodule

// File: rtl/spawn_join_dispatcher.sv
module spawn_join_dispatcher #(
   parameter int NUM_UNITS = 4,
   parameter int ID_W      = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      spawn_valid,
   input  logic [ID_W-1:0]           spawn_lo,
   input  logic [ID_W-1:0]           spawn_hi,
   output logic                      spawn_accept,
   output logic                      spawn_reject,
   output logic                      section_busy,
   input  logic [NUM_UNITS-1:0]      unit_req,
   input  logic [NUM_UNITS-1:0]      unit_done,
   output logic [NUM_UNITS-1:0]      unit_gnt,
   output logic [NUM_UNITS-1:0]      unit_none,
   output logic [NUM_UNITS*ID_W-1:0] unit_id,
   output logic                      join_done
);

   localparam int CNT_W = sjd_pkg::count_bits(NUM_UNITS);
   localparam int CW    = ID_W + CNT_W + 1;

   if (NUM_UNITS < 1 || NUM_UNITS > 64) begin : g_bad_units
      $error("spawn_join_dispatcher: NUM_UNITS must be 1..64");
   end
   if (ID_W < 1 || ID_W > 30) begin : g_bad_idw
      $error("spawn_join_dispatcher: ID_W must be 1..30");
   end

   logic                      busy;
   logic [CW-1:0]             next_id;
   logic [CW-1:0]             hi_bound;
   logic                      exhausted;
   logic [CNT_W-1:0]          take_cnt;
   logic                      units_clear;
   logic [NUM_UNITS-1:0]      grant_now;
   logic [NUM_UNITS-1:0]      deny_now;
   logic [NUM_UNITS*ID_W-1:0] id_now;
   logic [NUM_UNITS-1:0]      active;

   sjd_section_ctrl #(.ID_W(ID_W), .CNT_W(CNT_W), .CW(CW)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .spawn_valid  (spawn_valid),
      .spawn_lo     (spawn_lo),
      .spawn_hi     (spawn_hi),
      .take_cnt     (take_cnt),
      .units_clear  (units_clear),
      .busy         (busy),
      .next_id      (next_id),
      .hi_bound     (hi_bound),
      .exhausted    (exhausted),
      .spawn_accept (spawn_accept),
      .spawn_reject (spawn_reject),
      .join_done    (join_done)
   );

   sjd_id_allocator #(.NUM_UNITS(NUM_UNITS), .ID_W(ID_W), .CNT_W(CNT_W), .CW(CW)) u_alloc (
      .req       (unit_req),
      .busy      (busy),
      .next_id   (next_id),
      .hi_bound  (hi_bound),
      .grant_now (grant_now),
      .deny_now  (deny_now),
      .id_now    (id_now),
      .take_cnt  (take_cnt)
   );

   sjd_unit_tracker #(.NUM_UNITS(NUM_UNITS)) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .grant_now   (grant_now),
      .done        (unit_done),
      .active      (active),
      .units_clear (units_clear)
   );

   assign section_busy = busy;

   // Registered per-unit responses
   for (genvar i = 0; i < NUM_UNITS; i++) begin : g_resp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            unit_gnt[i]               <= 1'b0;
            unit_none[i]              <= 1'b0;
            unit_id[i*ID_W +: ID_W]   <= '0;
         end else begin
            unit_gnt[i]  <= grant_now[i];
            unit_none[i] <= deny_now[i];
            if (grant_now[i]) unit_id[i*ID_W +: ID_W] <= id_now[i*ID_W +: ID_W];
         end
      end
   end

   // R3: grants only appear while the section stays open
   assert_gnt_in_section_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_gnt != '0) |-> busy);

   // R8: at the join no unit still holds a thread
   assert_join_all_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
      join_done |-> (active == '0));

   // R10: nothing answers requests made with no section open
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(busy) |-> (unit_gnt == '0 && unit_none == '0));

   // R4: same-cycle grants are ordered by unit index
   always @(posedge clk) begin
      if (rst_n) begin
         for (int a = 0; a < NUM_UNITS; a++) begin
            for (int b = a + 1; b < NUM_UNITS; b++) begin
               if (unit_gnt[a] && unit_gnt[b]) begin
                  assert_grant_order_R4: assert (unit_id[a*ID_W +: ID_W] < unit_id[b*ID_W +: ID_W]);
               end
            end
         end
      end
   end

endmodule

// File: tb/spawn_join_dispatcher_tb.sv
module spawn_join_dispatcher_tb;

   localparam int NU   = 4;
   localparam int IDW  = 8;
   localparam int SPAN = 1 << IDW;
   localparam int NSEC = 7;
   // Section table: lower bound, upper bound (expected grant count derived)
   localparam int T_LO [NSEC] = '{0, 5, 3, 10, 250, 0, 100};
   localparam int T_HI [NSEC] = '{15, 5, 60, 9, 255, 1, 131};

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 spawn_valid = 1'b0;
   logic [IDW-1:0]       spawn_lo = '0;
   logic [IDW-1:0]       spawn_hi = '0;
   logic                 spawn_accept, spawn_reject, section_busy, join_done;
   logic [NU-1:0]        unit_req = '0;
   logic [NU-1:0]        unit_done = '0;
   logic [NU-1:0]        unit_gnt, unit_none;
   logic [NU*IDW-1:0]    unit_id;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   spawn_join_dispatcher #(.NUM_UNITS(NU), .ID_W(IDW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .spawn_valid(spawn_valid), .spawn_lo(spawn_lo), .spawn_hi(spawn_hi),
      .spawn_accept(spawn_accept), .spawn_reject(spawn_reject),
      .section_busy(section_busy),
      .unit_req(unit_req), .unit_done(unit_done),
      .unit_gnt(unit_gnt), .unit_none(unit_none), .unit_id(unit_id),
      .join_done(join_done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int uid(input int i);
      return int'(unit_id[i*IDW +: IDW]);
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // Random unit model for one section
   task automatic run_section(input int lo, input int hi);
      bit seen [SPAN];
      bit waitr [NU];
      bit run [NU];
      bit stopped [NU];
      int dur [NU];
      int expn, got, outst, t;
      bit joined;
      expn = (hi >= lo) ? (hi - lo + 1) : 0;
      got = 0; outst = 0; joined = 0;
      for (int k = 0; k < SPAN; k++) seen[k] = 1'b0;
      for (int i = 0; i < NU; i++) begin
         waitr[i] = 0; run[i] = 0; stopped[i] = 0; dur[i] = 0;
      end
      spawn_lo = IDW'(lo); spawn_hi = IDW'(hi); spawn_valid = 1'b1;
      @(negedge clk);
      spawn_valid = 1'b0;
      check(spawn_accept == 1'b1, "R1 accept", int'(spawn_accept), 1);
      t = 0;
      while (!joined && t < 3000) begin
         t++;
         for (int i = 0; i < NU; i++) begin
            if (waitr[i]) begin
               waitr[i] = 0;
               if (unit_gnt[i]) begin
                  check(uid(i) >= lo && uid(i) <= hi, "R6 in range", uid(i), lo);
                  check(!seen[uid(i)], "R6 unique", uid(i), -1);
                  seen[uid(i)] = 1'b1;
                  got++; outst++;
                  run[i] = 1; dur[i] = $urandom_range(0, 6);
               end else if (unit_none[i]) begin
                  stopped[i] = 1;
               end else begin
                  check(1'b0, "R3 response", 0, 1);
               end
            end
         end
         if (join_done) begin
            joined = 1;
            check(outst == 0 && got == expn, "R8 join not early", outst, 0);
            check(got == expn, "R6 count", got, expn);
            check(section_busy == 1'b0, "R7 busy falls", int'(section_busy), 0);
         end else begin
            unit_req = '0; unit_done = '0;
            for (int i = 0; i < NU; i++) begin
               if (run[i]) begin
                  if (dur[i] == 0) begin
                     unit_done[i] = 1'b1; run[i] = 0; outst--;
                  end else dur[i]--;
               end else if (!stopped[i] && $urandom_range(0, 3) != 0) begin
                  unit_req[i] = 1'b1; waitr[i] = 1;
               end
            end
            @(negedge clk);
         end
      end
      unit_req = '0; unit_done = '0;
      check(joined, "R7 join seen", int'(joined), 1);
      @(negedge clk);
      check(join_done == 1'b0, "R7 single pulse", int'(join_done), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: outputs in reset
      check(spawn_accept == 0 && spawn_reject == 0 && section_busy == 0 && join_done == 0,
            "R11 ctrl reset", int'(section_busy), 0);
      check(unit_gnt == '0 && unit_none == '0 && unit_id == '0, "R11 unit reset", int'(unit_gnt), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(section_busy == 0 && unit_gnt == '0, "R11 after release", int'(section_busy), 0);

      // R10: idle requests and dones ignored
      unit_req = '1; unit_done = '1;
      @(negedge clk);
      unit_req = '0; unit_done = '0;
      check(unit_gnt == '0 && unit_none == '0, "R10 idle quiet", int'({unit_gnt, unit_none}), 0);

      // Directed section 20..22
      spawn_lo = 8'd20; spawn_hi = 8'd22; spawn_valid = 1'b1;
      @(negedge clk);
      check(spawn_accept == 1 && section_busy == 1, "R1 accept busy", int'(spawn_accept), 1);
      unit_req = 4'b1011; spawn_lo = 8'd100; spawn_hi = 8'd200;
      @(negedge clk);
      spawn_valid = 1'b0; unit_req = '0;
      check(spawn_reject == 1 && spawn_accept == 0, "R2 reject", int'(spawn_reject), 1);
      check(unit_gnt == 4'b1011, "R3 grant mask", int'(unit_gnt), 11);
      check(uid(0) == 20, "R1 first id is lower bound", uid(0), 20);
      check(uid(1) == 21, "R4 second id", uid(1), 21);
      check(uid(3) == 22, "R4 third id", uid(3), 22);
      unit_req = 4'b0100;
      @(negedge clk);
      unit_req = '0;
      check(unit_none == 4'b0100 && unit_gnt == '0, "R5 none after range", int'(unit_none), 4);
      check(section_busy == 1, "R2 range unchanged", int'(section_busy), 1);
      unit_done = 4'b0011;
      @(negedge clk);
      unit_done = 4'b1000;
      check(join_done == 0 && section_busy == 1, "R8 no early join", int'(join_done), 0);
      @(negedge clk);
      unit_done = '0;
      check(join_done == 1 && section_busy == 0, "R7 join", int'(join_done), 1);
      @(negedge clk);
      check(join_done == 0, "R7 pulse width", int'(join_done), 0);

      // R9: empty range
      spawn_lo = 8'd9; spawn_hi = 8'd8; spawn_valid = 1'b1;
      @(negedge clk);
      spawn_valid = 1'b0;
      check(spawn_accept == 1, "R9 accept", int'(spawn_accept), 1);
      @(negedge clk);
      check(join_done == 1 && unit_gnt == '0, "R9 immediate join", int'(join_done), 1);
      @(negedge clk);

      // Table of sections walked by one loop (R3, R6, R8)
      for (int s = 0; s < NSEC; s++) begin
         run_section(T_LO[s], T_HI[s]);
         @(negedge clk);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule